// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a synchronous state machine that collects coins toward a single item priced at 45 cents. Three active-high strobes arrive from an upstream coin detector: one for a 5-cent coin, one for a 10-cent coin and one for a 25-cent coin. Each strobe is high for one clock cycle per coin. The machine keeps the running credit as its state, in 5-cent units, from 0 to 40 cents.

When a coin brings the total to 45 cents or more, the block raises a one-cycle dispense pulse and returns to zero credit. In that same cycle it reports any overpayment, in 5-cent units, to an external change mechanism. Coins of any mix are accepted, with or without quarters. A cycle in which more than one strobe is high is treated as invalid and leaves the credit untouched.

The credit register can be built one-hot or binary, chosen by a parameter. The ports behave the same way with either encoding.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low, credit_o, dispense_o and change_o are all zero, and the block starts from zero credit after reset is released.
- R2: credit_o gives the held credit in 5-cent units and always stays in the range 0 to 8.
- R3: A cycle with exactly one strobe high adds 1 unit for nickel_i, 2 for dime_i or 5 for quarter_i. If the new sum is below 9, credit_o shows the sum after the next rising edge and dispense_o stays low.
- R4: A single coin that brings the sum to 9 units or more sets dispense_o high after the next rising edge, and credit_o returns to 0 in that same cycle.
- R5: change_o equals the sum minus 9 in the cycle where dispense_o is high, and is 0 in every other cycle.
- R6: A cycle with two or three strobes high leaves credit_o unchanged and keeps dispense_o low.
- R7: A cycle with no strobe high leaves credit_o unchanged and keeps dispense_o low.
- R8: dispense_o is never high in two consecutive cycles.
- R9: Purchases made with no quarter at all (for example nine nickels, or four dimes and a nickel) dispense, and so do purchases made with several quarters (two quarters dispense with change 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | 5-cent coin strobe |
| dime_i | input | 1 | 10-cent coin strobe |
| quarter_i | input | 1 | 25-cent coin strobe |
| dispense_o | output | 1 | One-cycle dispense command |
| change_o | output | 3 | Overpayment in 5-cent units, valid while dispensing |
| credit_o | output | 4 | Held credit in 5-cent units |

## Verification
All three outputs are registered, so every result of a coin cycle shows up one rising edge after the strobe is sampled. Credit, dispense and change all change on that same edge. The bench changes the strobes on the falling edge. It compares all three outputs with its model at the next falling edge, which is half a period after the edge where they update. This holds for back-to-back coins and for idle cycles alike. The dispense pulse is checked again one cycle later to confirm that it has dropped.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef struct packed {
    logic quarter;
    logic dime;
    logic nickel;
  } coin_t;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned wid(int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
#(
  parameter int unsigned NICKEL_UNITS  = 1,
  parameter int unsigned DIME_UNITS    = 2,
  parameter int unsigned QUARTER_UNITS = 5,
  parameter int unsigned SUM_W         = 4
) (
  input  coin_t            coin_i,
  output logic             valid_o,
  output logic [SUM_W-1:0] units_o
);

  // exactly one strobe qualifies; anything else is an invalid cycle
  always_comb begin
    valid_o = 1'b1;
    units_o = '0;
    unique case (coin_i)
      coin_t'{quarter: 1'b0, dime: 1'b0, nickel: 1'b1}: units_o = SUM_W'(NICKEL_UNITS);
      coin_t'{quarter: 1'b0, dime: 1'b1, nickel: 1'b0}: units_o = SUM_W'(DIME_UNITS);
      coin_t'{quarter: 1'b1, dime: 1'b0, nickel: 1'b0}: units_o = SUM_W'(QUARTER_UNITS);
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vend_credit_calc.sv
module vend_credit_calc #(
  parameter int unsigned PRICE_UNITS = 9,
  parameter int unsigned CREDIT_W    = 4,
  parameter int unsigned SUM_W       = 4,
  parameter int unsigned CHANGE_W    = 3
) (
  input  logic [CREDIT_W-1:0] credit_i,
  input  logic                valid_i,
  input  logic [SUM_W-1:0]    units_i,
  output logic [CREDIT_W-1:0] credit_nxt_o,
  output logic                hit_o,
  output logic [CHANGE_W-1:0] change_nxt_o
);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum          = SUM_W'(credit_i) + units_i;
    hit_o        = valid_i && (sum >= SUM_W'(PRICE_UNITS));
    change_nxt_o = '0;
    credit_nxt_o = credit_i;
    if (hit_o) begin
      credit_nxt_o = '0;
      change_nxt_o = CHANGE_W'(sum - SUM_W'(PRICE_UNITS));
    end else if (valid_i) begin
      credit_nxt_o = CREDIT_W'(sum);
    end
  end

endmodule

// File: rtl/vend_credit_store.sv
module vend_credit_store #(
  parameter int unsigned PRICE_UNITS = 9,
  parameter int unsigned CREDIT_W    = 4,
  parameter bit          ONE_HOT     = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CREDIT_W-1:0] credit_d_i,
  output logic [CREDIT_W-1:0] credit_o
);

  if (ONE_HOT) begin : g_onehot
    logic [PRICE_UNITS-1:0] oh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) oh_q <= PRICE_UNITS'(1);
      else         oh_q <= PRICE_UNITS'(1) << credit_d_i;
    end

    always_comb begin
      credit_o = '0;
      for (int i = 0; i < int'(PRICE_UNITS); i++) begin
        if (oh_q[i]) credit_o = credit_o | CREDIT_W'(i);
      end
    end
  end else begin : g_binary
    logic [CREDIT_W-1:0] bin_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bin_q <= '0;
      else         bin_q <= credit_d_i;
    end

    assign credit_o = bin_q;
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned PRICE_UNITS   = 9,
  parameter int unsigned NICKEL_UNITS  = 1,
  parameter int unsigned DIME_UNITS    = 2,
  parameter int unsigned QUARTER_UNITS = 5,
  parameter bit          ONE_HOT       = 1'b1,
  localparam int unsigned MAX_COIN     = max3(NICKEL_UNITS, DIME_UNITS, QUARTER_UNITS),
  localparam int unsigned CREDIT_W     = wid(PRICE_UNITS),
  localparam int unsigned SUM_W        = wid(PRICE_UNITS + MAX_COIN),
  localparam int unsigned CHANGE_W     = wid(MAX_COIN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nickel_i,
  input  logic                dime_i,
  input  logic                quarter_i,
  output logic                dispense_o,
  output logic [CHANGE_W-1:0] change_o,
  output logic [CREDIT_W-1:0] credit_o
);

  coin_t               coin;
  logic                coin_valid;
  logic [SUM_W-1:0]    coin_units;
  logic [CREDIT_W-1:0] credit_nxt;
  logic                hit;
  logic [CHANGE_W-1:0] change_nxt;
  logic                dispense_q;
  logic [CHANGE_W-1:0] change_q;

  assign coin = coin_t'{quarter: quarter_i, dime: dime_i, nickel: nickel_i};

  vend_coin_decode #(
    .NICKEL_UNITS (NICKEL_UNITS),
    .DIME_UNITS   (DIME_UNITS),
    .QUARTER_UNITS(QUARTER_UNITS),
    .SUM_W        (SUM_W)
  ) u_decode (
    .coin_i (coin),
    .valid_o(coin_valid),
    .units_o(coin_units)
  );

  vend_credit_calc #(
    .PRICE_UNITS(PRICE_UNITS),
    .CREDIT_W   (CREDIT_W),
    .SUM_W      (SUM_W),
    .CHANGE_W   (CHANGE_W)
  ) u_calc (
    .credit_i    (credit_o),
    .valid_i     (coin_valid),
    .units_i     (coin_units),
    .credit_nxt_o(credit_nxt),
    .hit_o       (hit),
    .change_nxt_o(change_nxt)
  );

  vend_credit_store #(
    .PRICE_UNITS(PRICE_UNITS),
    .CREDIT_W   (CREDIT_W),
    .ONE_HOT    (ONE_HOT)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .credit_d_i(credit_nxt),
    .credit_o  (credit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dispense_q <= 1'b0;
      change_q   <= '0;
    end else begin
      dispense_q <= hit;
      change_q   <= change_nxt;
    end
  end

  assign dispense_o = dispense_q;
  assign change_o   = change_q;

endmodule

// File: rtl/vend_ctrl_sva.sv
module vend_ctrl_sva #(
  parameter int unsigned PRICE_UNITS  = 9,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned CREDIT_W     = 4,
  parameter int unsigned CHANGE_W     = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                nickel_i,
  input logic                dime_i,
  input logic                quarter_i,
  input logic                dispense_o,
  input logic [CHANGE_W-1:0] change_o,
  input logic [CREDIT_W-1:0] credit_o
);

  logic [2:0] coins;
  assign coins = {quarter_i, dime_i, nickel_i};

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (credit_o == '0 && !dispense_o && change_o == '0));

  assert_credit_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(credit_o) < int'(PRICE_UNITS));

  assert_nickel_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coins == 3'b001 && int'(credit_o) + int'(NICKEL_UNITS) < int'(PRICE_UNITS))
    |=> (int'(credit_o) == int'($past(credit_o)) + int'(NICKEL_UNITS) && !dispense_o));

  assert_dispense_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispense_o |-> credit_o == '0);

  assert_change_only_on_dispense_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispense_o |-> change_o == '0);

  assert_multi_coin_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(coins) > 1) |=> ($stable(credit_o) && !dispense_o));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coins == 3'b000) |=> ($stable(credit_o) && !dispense_o));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispense_o |=> !dispense_o);

endmodule

bind vend_ctrl vend_ctrl_sva #(
  .PRICE_UNITS (PRICE_UNITS),
  .NICKEL_UNITS(NICKEL_UNITS),
  .CREDIT_W    (CREDIT_W),
  .CHANGE_W    (CHANGE_W)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nickel_i  (nickel_i),
  .dime_i    (dime_i),
  .quarter_i (quarter_i),
  .dispense_o(dispense_o),
  .change_o  (change_o),
  .credit_o  (credit_o)
);

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nickel_i = 1'b0;
  logic       dime_i = 1'b0;
  logic       quarter_i = 1'b0;
  logic       dispense_o;
  logic [2:0] change_o;
  logic [3:0] credit_o;

  int checks = 0;
  int errors = 0;
  int m_credit = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vend_ctrl u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nickel_i  (nickel_i),
    .dime_i    (dime_i),
    .quarter_i (quarter_i),
    .dispense_o(dispense_o),
    .change_o  (change_o),
    .credit_o  (credit_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int weight(bit n, bit d, bit q);
    return n ? 1 : d ? 2 : 5;
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic step(bit n, bit d, bit q);
    int cnt, sum, e_disp, e_chg;
    string req;
    nickel_i = n; dime_i = d; quarter_i = q;
    cnt = int'(n) + int'(d) + int'(q);
    e_disp = 0; e_chg = 0;
    if (cnt == 1) begin
      sum = m_credit + weight(n, d, q);
      if (sum >= 9) begin
        e_disp = 1; e_chg = sum - 9; m_credit = 0; req = "R4";
      end else begin
        m_credit = sum; req = "R3";
      end
    end else if (cnt == 0) req = "R7";
    else req = "R6";
    @(negedge clk_i);
    chk(req, "credit", int'(credit_o), m_credit);
    chk(req, "dispense", int'(dispense_o), e_disp);
    chk("R5", "change", int'(change_o), e_chg);
    chk("R2", "credit range", int'(credit_o < 4'd9), 1);
  endtask

  task automatic idle_clear();
    nickel_i = 0; dime_i = 0; quarter_i = 0;
  endtask

  task automatic do_reset();
    idle_clear();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "credit in reset", int'(credit_o), 0);
    chk("R1", "dispense in reset", int'(dispense_o), 0);
    chk("R1", "change in reset", int'(change_o), 0);
    rst_ni = 1'b1;
    m_credit = 0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    do_reset();

    // every single-coin transition from every credit state
    for (int s = 0; s < 9; s++) begin
      for (int c = 0; c < 3; c++) begin
        do_reset();
        for (int k = 0; k < s; k++) step(1, 0, 0);
        chk("R2", "preload credit", int'(credit_o), s);
        step(c == 0, c == 1, c == 2);
        idle_clear();
        @(negedge clk_i);
        chk("R8", "dispense dropped", int'(dispense_o), 0);
      end
    end

    // R9: nine nickels
    do_reset();
    for (int k = 0; k < 8; k++) step(1, 0, 0);
    step(1, 0, 0);
    chk("R9", "nine nickels dispense", int'(dispense_o), 1);
    // R9: four dimes then a nickel
    for (int k = 0; k < 4; k++) step(0, 1, 0);
    step(1, 0, 0);
    chk("R9", "dimes+nickel dispense", int'(dispense_o), 1);
    chk("R9", "dimes+nickel change", int'(change_o), 0);
    // R9: two quarters, change 1, then a third quarter starts a new purchase
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R9", "two quarters dispense", int'(dispense_o), 1);
    chk("R9", "two quarters change", int'(change_o), 1);
    step(0, 0, 1);
    chk("R8", "no second pulse", int'(dispense_o), 0);
    chk("R9", "new credit", int'(credit_o), 5);

    // R6: every multi-coin combination from a nonzero credit
    step(0, 1, 1);
    step(1, 0, 1);
    step(1, 1, 0);
    step(1, 1, 1);
    chk("R6", "credit kept", int'(credit_o), 5);

    // R1: reset mid-purchase
    step(0, 1, 0);
    do_reset();
    chk("R1", "credit after release", int'(credit_o), 0);

    // random mix, multi-coin cycles included
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      case (r)
        0, 1:    step(0, 0, 0);
        2, 3, 4: step(1, 0, 0);
        5, 6:    step(0, 1, 0);
        7, 8:    step(0, 0, 1);
        default: step(1'($urandom), 1'b1, 1'b1);
      endcase
    end
    idle_clear();
    @(negedge clk_i);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule